// File: doc/BRIEF.md
# Header-Routed Four-Port Byte Switch

The switch takes a stream of bytes on one 8-bit input that has a valid/ready handshake. Each packet starts with a four-byte header: a destination byte, a source byte, a payload length and a control byte. The payload bytes that follow go to one of four 8-bit output ports. The low two bits of the destination byte pick the port. Bit 0 of the control byte decides whether the payload is delivered or dropped.

The chosen port takes a byte only while its read request is high. When the read request is low, the switch drops its input ready and the upstream source holds the byte. A port's ready output marks each cycle in which a byte is on that port's data bus. A done flag pulses once at the end of every packet. After that the parser waits for the next destination byte.

Top module: `byte_route_switch`

## Requirements
- R1: Accepted input bytes, meaning cycles with `in_valid_i` and `in_ready_o` both high, are taken in order as destination, source, length and control. Cycles with `in_valid_i` low are skipped. `in_ready_o` is high throughout the header, and the source byte has no effect on routing.
- R2: The output port index is destination bits [1:0]. Destination bits [7:2] have no effect on routing.
- R3: Exactly LENGTH payload bytes are forwarded. The byte after the last payload byte is parsed as the destination byte of a new packet.
- R4: When control bit 0 is 0, LENGTH payload bytes are accepted with `in_ready_o` high whatever the read requests are, and no port raises ready.
- R5: `port_rdy_o[p]` is high only in a cycle where port p is selected, control bit 0 is 1, `rd_req_i[p]` is high and a payload byte is accepted. In that cycle port p's data slice, bits [8p+7:8p], equals `in_data_i`.
- R6: During an enabled payload, `in_ready_o` is low while the selected port's `rd_req_i` is low. The held byte is not consumed.
- R7: A port whose ready is low drives zero on its data slice. At most one port is ready in any cycle.
- R8: `done_o` is high for exactly one cycle: the cycle after the last payload byte is accepted. This holds for delivered and dropped packets alike.
- R9: With LENGTH 0, `done_o` pulses in the cycle after the control byte is accepted, and no payload is taken.
- R10: Asserting `rst_ni` low clears the header registers and the counter, lowers every port ready and `done_o`, and returns the parser to waiting for a destination byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_data_i | input | 8 | Input byte |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Switch can accept the input byte |
| rd_req_i | input | 4 | Per-port read request |
| port_rdy_o | output | 4 | Per-port byte-present strobe |
| port_data_o | output | 32 | Port data, port p in bits [8p+7:8p] |
| done_o | output | 1 | One-cycle end-of-packet pulse |

## Verification
The assertions check several rules on every cycle:
- at most one port is ready;
- a ready port has its read request high and carries exactly the accepted input byte;
- idle ports drive zero;
- no port is ready while input ready is low;
- done never lasts two cycles.

Some behaviour only the directed scenarios can show: the header field order, the fact that upper destination bits and the source byte have no effect, the exact payload count, alignment to the following header, dropping on a cleared enable bit, the zero-length case, and recovery from a reset in mid-packet.

// File: rtl/sw_pkg.sv
package sw_pkg;
  typedef enum logic [2:0] {
    PH_DST,
    PH_SRC,
    PH_LEN,
    PH_CTL,
    PH_PAY
  } phase_e;
endpackage

// File: rtl/sw_hdr_parser.sv
module sw_hdr_parser
  import sw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              valid_i,
  input  logic              sel_rd_i,
  output logic              ready_o,
  output logic              fwd_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              done_o
);
  phase_e            phase_q;
  logic [DATA_W-1:0] dst_q, src_q, len_q, ctl_q, cnt_q;
  logic              done_q;
  logic              accept;
  logic              unused_hdr;

  // header stalls never; payload stalls only when enabled and port not reading
  always_comb begin
    ready_o = (phase_q != PH_PAY) || !ctl_q[0] || sel_rd_i;
  end

  assign accept     = valid_i && ready_o;
  assign fwd_o      = (phase_q == PH_PAY) && ctl_q[0] && accept;
  assign sel_o      = dst_q[SEL_W-1:0];
  assign done_o     = done_q;
  assign unused_hdr = ^{src_q, dst_q[DATA_W-1:SEL_W], ctl_q[DATA_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_DST;
      dst_q   <= '0;
      src_q   <= '0;
      len_q   <= '0;
      ctl_q   <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        unique case (phase_q)
          PH_DST: begin
            dst_q   <= byte_i;
            phase_q <= PH_SRC;
          end
          PH_SRC: begin
            src_q   <= byte_i;
            phase_q <= PH_LEN;
          end
          PH_LEN: begin
            len_q   <= byte_i;
            phase_q <= PH_CTL;
          end
          PH_CTL: begin
            ctl_q <= byte_i;
            if (len_q == '0) begin
              done_q  <= 1'b1;
              phase_q <= PH_DST;
            end else begin
              cnt_q   <= len_q;
              phase_q <= PH_PAY;
            end
          end
          PH_PAY: begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == DATA_W'(1)) begin
              done_q  <= 1'b1;
              phase_q <= PH_DST;
            end
          end
          default: phase_q <= PH_DST;
        endcase
      end
    end
  end
endmodule

// File: rtl/sw_port_fanout.sv
module sw_port_fanout #(
  parameter int DATA_W  = 8,
  parameter int N_PORTS = 4,
  parameter int SEL_W   = 2
) (
  input  logic [DATA_W-1:0]         byte_i,
  input  logic                      fwd_i,
  input  logic [SEL_W-1:0]          sel_i,
  output logic [N_PORTS-1:0]        rdy_o,
  output logic [N_PORTS*DATA_W-1:0] data_o
);
  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    assign rdy_o[p] = fwd_i && (sel_i == SEL_W'(p));
    assign data_o[p*DATA_W +: DATA_W] = rdy_o[p] ? byte_i : '0;
  end
endmodule

// File: rtl/byte_route_switch.sv
module byte_route_switch #(
  parameter int DATA_W  = 8,
  parameter int N_PORTS = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [DATA_W-1:0]         in_data_i,
  input  logic                      in_valid_i,
  output logic                      in_ready_o,
  input  logic [N_PORTS-1:0]        rd_req_i,
  output logic [N_PORTS-1:0]        port_rdy_o,
  output logic [N_PORTS*DATA_W-1:0] port_data_o,
  output logic                      done_o
);
  localparam int SEL_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

  logic [SEL_W-1:0] sel;
  logic             fwd;
  logic             sel_rd;

  assign sel_rd = rd_req_i[sel];

  sw_hdr_parser #(
    .DATA_W(DATA_W),
    .SEL_W (SEL_W)
  ) u_parser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .byte_i  (in_data_i),
    .valid_i (in_valid_i),
    .sel_rd_i(sel_rd),
    .ready_o (in_ready_o),
    .fwd_o   (fwd),
    .sel_o   (sel),
    .done_o  (done_o)
  );

  sw_port_fanout #(
    .DATA_W (DATA_W),
    .N_PORTS(N_PORTS),
    .SEL_W  (SEL_W)
  ) u_fanout (
    .byte_i(in_data_i),
    .fwd_i (fwd),
    .sel_i (sel),
    .rdy_o (port_rdy_o),
    .data_o(port_data_o)
  );
endmodule

// File: rtl/sw_checker.sv
module sw_checker #(
  parameter int DATA_W  = 8,
  parameter int N_PORTS = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [DATA_W-1:0]         in_data_i,
  input logic                      in_valid_i,
  input logic                      in_ready_o,
  input logic [N_PORTS-1:0]        rd_req_i,
  input logic [N_PORTS-1:0]        port_rdy_o,
  input logic [N_PORTS*DATA_W-1:0] port_data_o,
  input logic                      done_o
);
  assert_one_port_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(port_rdy_o));

  assert_stall_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |-> (port_rdy_o == '0));

  assert_rdy_needs_byte_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_rdy_o != '0) |-> in_valid_i);

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  for (genvar p = 0; p < N_PORTS; p++) begin : g_chk
    assert_rdy_needs_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      port_rdy_o[p] |-> rd_req_i[p]);
    assert_data_match_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      port_rdy_o[p] |-> (port_data_o[p*DATA_W +: DATA_W] == in_data_i));
    assert_idle_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !port_rdy_o[p] |-> (port_data_o[p*DATA_W +: DATA_W] == '0));
  end
endmodule

bind byte_route_switch sw_checker #(
  .DATA_W (DATA_W),
  .N_PORTS(N_PORTS)
) u_sw_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_data_i  (in_data_i),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .rd_req_i   (rd_req_i),
  .port_rdy_o (port_rdy_o),
  .port_data_o(port_data_o),
  .done_o     (done_o)
);

// File: tb/tb_byte_route_switch.sv
`timescale 1ns/1ps
module tb_byte_route_switch;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  in_data_i = '0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [3:0]  rd_req_i = '0;
  logic [3:0]  port_rdy_o;
  logic [31:0] port_data_o;
  logic        done_o;

  int total = 0;
  int bad = 0;

  always #10 clk_i = ~clk_i;

  byte_route_switch dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_data_i  (in_data_i),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .rd_req_i   (rd_req_i),
    .port_rdy_o (port_rdy_o),
    .port_data_o(port_data_o),
    .done_o     (done_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic put_byte(input logic [7:0] b, input int gap);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk_i);
      in_valid_i = 1'b0;
      in_data_i  = 8'h00;
      #1;
      chk("R7", {28'h0, port_rdy_o}, 32'h0);
    end
    @(negedge clk_i);
    in_data_i  = b;
    in_valid_i = 1'b1;
    #1;
  endtask

  task automatic run_pkt(input string ptag, input string dtag,
                         input logic [7:0] dst, input logic [7:0] src,
                         input logic [7:0] len, input logic [7:0] ctl,
                         input logic [7:0] base, input int gap, input int stall);
    logic [7:0] hdr [4];
    logic [1:0] sel;
    logic       en;
    logic [3:0] save;
    hdr[0] = dst; hdr[1] = src; hdr[2] = len; hdr[3] = ctl;
    sel = dst[1:0];
    en  = ctl[0];
    for (int i = 0; i < 4; i++) begin
      put_byte(hdr[i], gap);
      chk("R1", {31'h0, in_ready_o}, 32'h1);
      chk("R7", {28'h0, port_rdy_o}, 32'h0);
    end
    for (int k = 0; k < int'(len); k++) begin
      put_byte(base + 8'(k), gap);
      if (stall > 0 && k == 0 && en) begin
        save = rd_req_i;
        rd_req_i[sel] = 1'b0;
        #1;
        for (int s = 0; s < stall; s++) begin
          chk("R6", {31'h0, in_ready_o}, 32'h0);
          chk("R6", {28'h0, port_rdy_o}, 32'h0);
          @(negedge clk_i);
          #1;
        end
        rd_req_i = save;
        #1;
      end
      chk(ptag, {31'h0, in_ready_o}, 32'h1);
      chk(ptag, {28'h0, port_rdy_o}, en ? (32'h1 << sel) : 32'h0);
      chk(ptag, port_data_o, en ? ({24'h0, base + 8'(k)} << (8 * sel)) : 32'h0);
      chk("R8", {31'h0, done_o}, 32'h0);
    end
    @(negedge clk_i);
    in_valid_i = 1'b0;
    in_data_i  = 8'h00;
    #1;
    chk(dtag, {31'h0, done_o}, 32'h1);
    chk(dtag, {28'h0, port_rdy_o}, 32'h0);
    @(negedge clk_i);
    #1;
    chk(dtag, {31'h0, done_o}, 32'h0);
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    #1;
    chk("R10", {31'h0, in_ready_o}, 32'h1);
    chk("R10", {28'h0, port_rdy_o}, 32'h0);
    chk("R10", port_data_o, 32'h0);
    chk("R10", {31'h0, done_o}, 32'h0);
  endtask

  task automatic t_mid_reset;
    rd_req_i = 4'hF;
    put_byte(8'h01, 0);
    put_byte(8'h11, 0);
    put_byte(8'h05, 0);
    put_byte(8'h01, 0);
    put_byte(8'hAA, 0);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk("R10", {28'h0, port_rdy_o}, 32'h0);
    chk("R10", {31'h0, done_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // restart: next byte must be a destination byte
    run_pkt("R10", "R8", 8'h43, 8'h00, 8'd2, 8'h01, 8'h70, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    rd_req_i = 4'hF;
    run_pkt("R3", "R8", 8'h01, 8'h55, 8'd3, 8'h01, 8'h10, 0, 0);
    rd_req_i = 4'b0100;
    run_pkt("R2", "R8", 8'hFE, 8'h02, 8'd2, 8'h81, 8'h20, 2, 0);
    rd_req_i = 4'h0;
    run_pkt("R4", "R8", 8'h03, 8'h03, 8'd3, 8'hFE, 8'h30, 0, 0);
    rd_req_i = 4'hF;
    run_pkt("R9", "R9", 8'h00, 8'h01, 8'd0, 8'h01, 8'h00, 1, 0);
    rd_req_i = 4'hF;
    run_pkt("R5", "R8", 8'h00, 8'hC3, 8'd4, 8'h01, 8'h40, 0, 3);
    rd_req_i = 4'b1000;
    run_pkt("R3", "R8", 8'h7F, 8'h00, 8'd1, 8'h01, 8'h50, 0, 0);
    t_mid_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule